// File: doc/BRIEF.md
# Edge-Pulse Level Link with Refresh and Watchdog

This block moves one logic level across a channel that carries only single-cycle pulses. A transmitter half watches the input bit. It sends a set pulse on each rising edge and a clear pulse on each falling edge. While the input stays still, it repeats a pulse of the matching polarity at a fixed spacing, so the far side never drifts from the true level.

The receiver half is a bistable latch that a set pulse drives high and a clear pulse drives low. A watchdog counts the cycles since the last pulse of either kind. If it runs out, the receiver forces its output low and drops a link-good flag. The next pulse raises the flag again and sets the level. Both halves share one clock. The channel between them is brought out as ports, so the integrator wires the transmit pins to the receive pins, or through any path that carries pulses.

All timing limits are counted in clock cycles. The input goes through a synchronizer of SYNC_STAGES flops. The watchdog limit must be well above the refresh spacing; the defaults put it at four times that spacing.

Top module: `pulse_link`

## Requirements
- R1: While rst_ni is low, data_o, link_ok_o, tx_set_o and tx_clr_o are all 0.
- R2: A rising edge of data_i gives exactly one single-cycle pulse on tx_set_o, and a falling edge gives one on tx_clr_o. The two are never high in the same cycle.
- R3: With the default two-stage synchronizer, a change of data_i sampled at clock edge k appears as a transmit pulse after edge k+2. With tx wired straight to rx, it appears on data_o after edge k+3.
- R4: While data_i holds still, a transmit pulse repeats every REFRESH_CYC cycles. It appears on tx_set_o if the level is 1 and on tx_clr_o if it is 0.
- R5: Every transmit pulse, whether from an edge or a refresh, restarts the refresh spacing. The next refresh comes REFRESH_CYC cycles after an edge pulse.
- R6: A received set pulse drives data_o to 1 and a received clear pulse drives it to 0, one cycle later. Between pulses data_o holds its value.
- R7: If no pulse arrives on rx_set_i or rx_clr_i for WDOG_CYC cycles, data_o and link_ok_o go to 0 and stay there until a pulse arrives.
- R8: A received pulse sets link_ok_o to 1 one cycle later, and the same pulse sets the level of data_o.
- R9: After reset is released, the first transmit pulse comes exactly REFRESH_CYC cycles later and shows the synchronized input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Level to carry; may be asynchronous |
| tx_set_o | output | 1 | Transmit set pulse, one cycle wide |
| tx_clr_o | output | 1 | Transmit clear pulse, one cycle wide |
| rx_set_i | input | 1 | Received set pulse |
| rx_clr_i | input | 1 | Received clear pulse |
| data_o | output | 1 | Recovered level |
| link_ok_o | output | 1 | 1 while pulses keep arriving inside the watchdog limit |

## Verification
The receiver assertions assume that rx_set_i and rx_clr_i are never high in the same cycle. The bench keeps to this because it drives the receive pins only from the transmit pins, gated by a single cut signal. The transmitter assertions take the synchronized input as given. The bench changes data_i only on falling clock edges and holds each value for at least one cycle. A behavioural model with a sample-history queue predicts the transmit pulses, data_o and link_ok_o on every clock, including while the link is cut and after it is restored.

// File: rtl/pulse_link_pkg.sv
package pulse_link_pkg;
  typedef struct packed {
    logic set;
    logic clr;
  } pulse_t;
endpackage

// File: rtl/pl_sync.sv
module pl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES < 2) begin : g_bad
      $error("pl_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pl_encoder.sv
module pl_encoder
  import pulse_link_pkg::*;
#(
  parameter int unsigned REFRESH_CYC = 160
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   level_i,
  output pulse_t pulse_o
);
  localparam int unsigned CW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [CW-1:0] DUE = CW'(REFRESH_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          last_q;
  pulse_t        pulse_q;
  logic          edge_seen, due, fire;

  assign edge_seen = level_i ^ last_q;
  assign due       = (cnt_q == DUE);
  assign fire      = edge_seen | due;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      last_q  <= 1'b0;
      pulse_q <= '0;
    end else begin
      last_q      <= level_i;
      cnt_q       <= fire ? '0 : cnt_q + 1'b1;
      pulse_q.set <= fire & level_i;
      pulse_q.clr <= fire & ~level_i;
    end
  end

  assign pulse_o = pulse_q;

  a_r2_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_q.set && pulse_q.clr));
  a_r2_set_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q.set |=> !pulse_q.set);
  a_r2_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q.clr |=> !pulse_q.clr);
  a_r4_set_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q.set |-> last_q);
  a_r5_edge_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i != last_q) |=> (pulse_q.set || pulse_q.clr));
endmodule

// File: rtl/pl_decoder.sv
module pl_decoder
  import pulse_link_pkg::*;
#(
  parameter int unsigned WDOG_CYC = 640
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  pulse_t pulse_i,
  output logic   level_o,
  output logic   ok_o
);
  localparam int unsigned CW = (WDOG_CYC > 2) ? $clog2(WDOG_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYC - 1);

  logic [CW-1:0] wd_q;
  logic          level_q, ok_q, hit, expire;

  assign hit    = pulse_i.set | pulse_i.clr;
  assign expire = (wd_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q    <= '0;
      level_q <= 1'b0;
      ok_q    <= 1'b0;
    end else if (hit) begin
      wd_q    <= '0;
      ok_q    <= 1'b1;
      level_q <= pulse_i.set;
    end else if (expire) begin
      level_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      wd_q <= wd_q + 1'b1;
    end
  end

  assign level_o = level_q;
  assign ok_o    = ok_q;

  a_r2_rx_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pulse_i.set && pulse_i.clr));
  a_r6_rise_from_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_q) |-> $past(pulse_i.set));
  a_r6_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_q) |-> ($past(pulse_i.clr) || $fell(ok_q)));
  a_r7_low_when_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_q |-> !level_q);
  a_r8_ok_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> ok_q);
endmodule

// File: rtl/pulse_link.sv
module pulse_link
  import pulse_link_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REFRESH_CYC = 160,
  parameter int unsigned WDOG_CYC    = 640
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic tx_set_o,
  output logic tx_clr_o,
  input  logic rx_set_i,
  input  logic rx_clr_i,
  output logic data_o,
  output logic link_ok_o
);
  generate
    if (WDOG_CYC <= REFRESH_CYC + 1) begin : g_bad_limits
      $error("WDOG_CYC must exceed REFRESH_CYC");
    end
  endgenerate

  logic   level_sync;
  pulse_t tx_pulse, rx_pulse;

  pl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (data_i),
    .q_o   (level_sync)
  );

  pl_encoder #(.REFRESH_CYC(REFRESH_CYC)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(level_sync),
    .pulse_o(tx_pulse)
  );

  assign tx_set_o     = tx_pulse.set;
  assign tx_clr_o     = tx_pulse.clr;
  assign rx_pulse.set = rx_set_i;
  assign rx_pulse.clr = rx_clr_i;

  pl_decoder #(.WDOG_CYC(WDOG_CYC)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(rx_pulse),
    .level_o(data_o),
    .ok_o   (link_ok_o)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !(tx_set_o || tx_clr_o || data_o || link_ok_o));
endmodule

// File: tb/pulse_link_test.sv
module pulse_link_test;
  localparam int R = 160;
  localparam int W = 640;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic cut = 1'b0;
  logic tx_set, tx_clr, dout, ok;
  logic rx_set, rx_clr;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  assign rx_set = tx_set & ~cut;
  assign rx_clr = tx_clr & ~cut;

  pulse_link #(.SYNC_STAGES(2), .REFRESH_CYC(R), .WDOG_CYC(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(din),
    .tx_set_o(tx_set), .tx_clr_o(tx_clr),
    .rx_set_i(rx_set), .rx_clr_i(rx_clr),
    .data_o(dout), .link_ok_o(ok)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic hist[$];
  bit   m_set, m_clr, m_out, m_ok;
  int   since, quiet;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{1'b0, 1'b0, 1'b0};
      m_set = 0; m_clr = 0; m_out = 0; m_ok = 0;
      since = 0; quiet = 0;
    end else begin
      bit rs, rc, lvl, fire;
      rs = m_set && !cut;
      rc = m_clr && !cut;
      if (rs || rc) begin
        quiet = 0; m_ok = 1; m_out = rs;
      end else if (quiet == W - 1) begin
        m_out = 0; m_ok = 0;
      end else begin
        quiet++;
      end
      lvl   = hist[1];
      fire  = (hist[1] != hist[2]) || (since == R - 1);
      since = fire ? 0 : since + 1;
      m_set = fire && lvl;
      m_clr = fire && !lvl;
      hist.push_front(din);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag, "tx_set_o", tx_set, m_set);
      chk(tag, "tx_clr_o", tx_clr, m_clr);
      chk(tag, "data_o", dout, m_out);
      chk(tag, "link_ok_o", ok, m_ok);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "data_o in reset", dout, 0);
    chk("R1", "link_ok_o in reset", ok, 0);
    chk("R1", "tx pulses in reset", tx_set | tx_clr, 0);
    rst_n = 1'b1;
    tag = "R9";
    // R9: first pulse exactly R cycles after release, clear level
    gap = 0;
    for (int i = 1; i <= R + 5; i++) begin
      @(negedge clk);
      if ((tx_set || tx_clr) && gap == 0) begin
        gap = i;
        chk("R9", "first pulse is clear", tx_clr, 1);
      end
    end
    chk("R9", "first pulse delay", gap, R);

    // R3: latency input -> data_o
    tag = "R3";
    din = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3", "data_o before latency", dout, 0);
    @(negedge clk);
    chk("R3", "data_o after latency", dout, 1);
    repeat (4) @(negedge clk);
    din = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3", "no tx pulse before k+2", tx_clr, 0);
    @(negedge clk);
    chk("R3", "clear pulse at k+2", tx_clr, 1);
    @(negedge clk);
    chk("R6", "data_o cleared", dout, 0);

    // R2 and R6: varied toggle patterns, compared by the model
    tag = "R2";
    for (int p = 1; p <= 4; p++) begin
      for (int t = 0; t < 6; t++) begin
        din = ~din;
        repeat (p) @(negedge clk);
      end
    end
    tag = "R6";
    din = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6", "data_o holds high", dout, 1);

    // R4: refresh spacing while idle at level 1
    tag = "R4";
    while (!tx_set) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tx_set && gap < 2 * R);
    chk("R4", "set refresh spacing", gap, R);

    // R5: an edge restarts the spacing
    tag = "R5";
    repeat (50) @(negedge clk);
    din = 1'b0;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tx_clr && gap < 10);
    chk("R5", "edge pulse delay", gap, 3);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tx_clr && gap < 2 * R);
    chk("R5", "refresh after edge", gap, R);
    chk("R4", "refresh polarity low", tx_set, 0);

    // R7: cut the link
    tag = "R7";
    din = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7", "data_o high before cut", dout, 1);
    cut = 1'b1;
    gap = 0;
    do begin @(negedge clk); gap++; end while (ok && gap < W + R + 10);
    chk("R7", "watchdog fired in window", int'(gap <= W + 1 && gap >= W - R), 1);
    chk("R7", "data_o forced low", dout, 0);
    repeat (100) @(negedge clk);
    chk("R7", "link_ok_o stays low", ok, 0);

    // R8: restore link
    tag = "R8";
    cut = 1'b0;
    while (!tx_set) @(negedge clk);
    @(negedge clk);
    chk("R8", "link_ok_o restored", ok, 1);
    chk("R8", "data_o from pulse", dout, 1);
    repeat (20) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule